// File: doc/BRIEF.md
# Linked Descriptor Ring Sequencer

This block drives a data mover from a chain of descriptors that sit in system memory. After software loads the address of the first descriptor and issues a start command, the sequencer reads the descriptor as three 32-bit words over a single-beat read port. It then presents the buffer address and byte count to the mover as one segment request and waits for the mover's completion strobe. When the segment finishes, it pulses a per-link completion event, adds the segment length to a running byte counter and moves on to the descriptor named by the next pointer.

A chain whose last next pointer leads back to its first descriptor forms a ring, and the sequencer keeps walking that ring until it is told to halt. A next pointer of zero ends the chain and returns the sequencer to idle. A descriptor with a zero byte count produces a completion event without a segment, so rings may hold placeholder links. Stop lets the current segment finish before halting. Abort halts at once and tells the mover to flush. A failed descriptor read halts the sequencer and raises an error event.

Top module: `ldr_seq`

## Requirements
- R1: After reset the sequencer is inactive: mem_rd_req, seg_valid, evt_link_done, evt_xfer_err and seg_flush are low and dev_byte_cnt is 0.
- R2: An accepted start takes the first descriptor address from the link register as it stood before that cycle, so a link_wr in the same cycle only affects later starts. The three words are then read in the order count, buffer address, next pointer, at byte offsets 0, 4 and 8 from the descriptor address. Each mem_rd_addr is held with mem_rd_req high until a cycle with mem_rd_ack.
- R3: After the third word, a nonzero count drives seg_valid high with seg_addr and seg_len equal to the fetched buffer address and count. These stay stable until the cycle in which seg_done is sampled high.
- R4: evt_link_done is high for exactly one cycle after each descriptor finishes. A descriptor with count 0 raises it without ever asserting seg_valid.
- R5: After evt_link_done, the next fetch starts at the fetched next pointer. A next pointer equal to an earlier descriptor keeps the walk cycling. A next pointer of 0 returns the block to inactive.
- R6: dev_byte_cnt grows by seg_len in the cycle after each accepted seg_done. A cnt_clr strobe sets it to 0. A cnt_clr in the same cycle as a completion leaves it equal to that segment's length.
- R7: cmd_abort in any active state makes the block inactive on the next cycle, with mem_rd_req and seg_valid low, seg_flush high for one cycle, and no count added.
- R8: cmd_stop in an active state halts at the next boundary. A segment in flight completes, is counted and raises evt_link_done, and then no further fetch is made. During a fetch, the block halts on the next mem_rd_ack without issuing a segment.
- R9: A mem_rd_ack with mem_rd_err high during a fetch makes the block inactive, pulses evt_xfer_err for one cycle and issues no segment.
- R10: cmd_start is ignored while the block is active and accepted when it is idle or halted. cmd_stop is ignored when the block is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start walking from the link register |
| cmd_stop | input | 1 | Halt after the current segment or fetch |
| cmd_abort | input | 1 | Halt immediately and flush the mover |
| link_wr | input | 1 | Load the link register |
| link_wdata | input | ADDR_W | First descriptor address |
| cnt_clr | input | 1 | Clear the byte counter |
| mem_rd_req | output | 1 | Descriptor word read request |
| mem_rd_addr | output | ADDR_W | Descriptor word byte address |
| mem_rd_ack | input | 1 | Read response valid, completes the request |
| mem_rd_data | input | 32 | Read response word |
| mem_rd_err | input | 1 | Read response carries an error |
| seg_valid | output | 1 | Segment request to the mover |
| seg_addr | output | ADDR_W | Segment buffer address |
| seg_len | output | 32 | Segment byte count |
| seg_done | input | 1 | Mover finished the segment |
| seg_flush | output | 1 | Mover must discard buffered data |
| evt_link_done | output | 1 | One descriptor completed |
| evt_xfer_err | output | 1 | Descriptor read failed |
| dev_byte_cnt | output | CNT_W | Bytes moved since the last clear |
| active | output | 1 | Sequencer is walking a chain |

## Verification
The first pattern is a zero-terminated two-link chain. It separates chain termination from ring cycling and checks the accumulated count against the sum of the two lengths. A three-link ring with a zero-count placeholder is run for more than two laps. Because the number of completion events differs from the number of segments there, a skip that wrongly issues a segment, or a loop that stops following pointers, is exposed. With the mover held in mid-segment, the block receives start, stop and abort, and receives abort again during a fetch. These show whether each command acts at once, at the boundary, or not at all. An erroring descriptor address, a link write that coincides with a start, and a counter clear that coincides with a completion fix the ordering of those same-cycle events, with random read latency and mover delays throughout.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int DESC_WORDS = 3;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FETCH0 = 3'd1,
    ST_FETCH1 = 3'd2,
    ST_FETCH2 = 3'd3,
    ST_XFER   = 3'd4,
    ST_NEXT   = 3'd5,
    ST_HALT   = 3'd6
  } ldr_state_e;

  // Word slot of a fetch state: 0 = count, 1 = buffer address, 2 = next pointer.
  function automatic logic [1:0] fetch_slot(ldr_state_e s);
    case (s)
      ST_FETCH1: return 2'd1;
      ST_FETCH2: return 2'd2;
      default:   return 2'd0;
    endcase
  endfunction

  // Byte offset of a word slot inside a descriptor.
  function automatic logic [3:0] slot_offset(logic [1:0] slot);
    return {slot, 2'b00};
  endfunction

  function automatic logic is_fetch(ldr_state_e s);
    return (s == ST_FETCH0) || (s == ST_FETCH1) || (s == ST_FETCH2);
  endfunction

  function automatic logic is_running(ldr_state_e s);
    return is_fetch(s) || (s == ST_XFER) || (s == ST_NEXT);
  endfunction

  // Counter update: an optional clear followed by an optional add.
  function automatic logic [63:0] accumulate(logic [63:0] cur, logic clr,
                                             logic add, logic [63:0] val);
    return (clr ? 64'd0 : cur) + (add ? val : 64'd0);
  endfunction
endpackage

// File: rtl/ldr_word_order.sv
module ldr_word_order #(
  parameter int W         = 32,
  parameter bit SWAP_BYTE = 1'b0
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NBYTES = W / 8;

  // Descriptor words are little-endian; a bus that delivers the other byte
  // order is corrected here.
  generate
    if (SWAP_BYTE) begin : g_swap
      for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign dout[8*b +: 8] = din[8*(NBYTES-1-b) +: 8];
      end
    end else begin : g_pass
      assign dout = din;
    end
  endgenerate
endmodule

// File: rtl/ldr_desc_regs.sv
module ldr_desc_regs #(
  parameter int W     = 32,
  parameter int NWORD = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cap_en,
  input  logic [$clog2(NWORD)-1:0] cap_slot,
  input  logic [W-1:0]             cap_word,
  output logic [W-1:0]             word_q [NWORD]
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int SLOT_W = $clog2(NWORD);

  generate
    for (genvar i = 0; i < NWORD; i++) begin : g_word
      logic hit;
      assign hit = cap_en && (cap_slot == SLOT_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   word_q[i] <= '0;
        else if (hit) word_q[i] <= cap_word;
      end
    end
  endgenerate
endmodule

// File: rtl/ldr_byte_counter.sv
module ldr_byte_counter #(
  parameter int CNT_W = 32,
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add_en,
  input  logic [LEN_W-1:0] add_val,
  output logic [CNT_W-1:0] cnt
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [63:0] sum64;
  assign sum64 = ldr_pkg::accumulate(64'(cnt), clr, add_en, 64'(add_val));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= sum64[CNT_W-1:0];
  end

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !add_en) |=> (cnt == '0)); // R6

  AST_CNT_ACCUM: assert property (@(posedge clk) disable iff (!rst_n)
    (add_en && !clr) |=> (cnt == CNT_W'($past(cnt) + CNT_W'($past(add_val))))); // R6

  AST_CNT_CLEAR_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (add_en && clr) |=> (cnt == CNT_W'($past(add_val)))); // R6
endmodule

// File: rtl/ldr_seq.sv
module ldr_seq #(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 32,
  parameter bit SWAP_BYTE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              cmd_abort,
  input  logic              link_wr,
  input  logic [ADDR_W-1:0] link_wdata,
  input  logic              cnt_clr,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_ack,
  input  logic [31:0]       mem_rd_data,
  input  logic              mem_rd_err,
  output logic              seg_valid,
  output logic [ADDR_W-1:0] seg_addr,
  output logic [31:0]       seg_len,
  input  logic              seg_done,
  output logic              seg_flush,
  output logic              evt_link_done,
  output logic              evt_xfer_err,
  output logic [CNT_W-1:0]  dev_byte_cnt,
  output logic              active
);
  timeunit 1ns;
  timeprecision 1ps;
  import ldr_pkg::*;

  localparam int SLOT_W = $clog2(DESC_WORDS);

  ldr_state_e        state, state_d;
  logic [ADDR_W-1:0] link_reg, cur_desc;
  logic              stop_pend, err_q, flush_q;

  // Named internal events.
  logic              running, fetching, start_acc, abort_acc, stop_eff;
  logic              fetch_ok, fetch_bad, seg_fin, len_zero, chain_end;
  logic [SLOT_W-1:0] slot;
  logic [WORD_W-1:0] word_in;
  logic [WORD_W-1:0] dword [DESC_WORDS];
  logic [WORD_W-1:0] desc_len, desc_buf, desc_next;

  assign running   = is_running(state);
  assign fetching  = is_fetch(state);
  assign start_acc = !running && cmd_start && !cmd_abort;
  assign abort_acc = running && cmd_abort;
  assign stop_eff  = stop_pend || cmd_stop;
  assign fetch_ok  = fetching && mem_rd_ack && !mem_rd_err && !cmd_abort;
  assign fetch_bad = fetching && mem_rd_ack && mem_rd_err && !cmd_abort;
  assign seg_fin   = (state == ST_XFER) && seg_done && !cmd_abort;
  assign slot      = SLOT_W'(fetch_slot(state));

  ldr_word_order #(.W(WORD_W), .SWAP_BYTE(SWAP_BYTE)) u_order (
    .din  (mem_rd_data),
    .dout (word_in)
  );

  ldr_desc_regs #(.W(WORD_W), .NWORD(DESC_WORDS)) u_desc (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (fetch_ok),
    .cap_slot (slot),
    .cap_word (word_in),
    .word_q   (dword)
  );

  assign desc_len  = dword[0];
  assign desc_buf  = dword[1];
  assign desc_next = dword[2];
  assign len_zero  = (desc_len == '0);
  assign chain_end = (desc_next == '0);

  ldr_byte_counter #(.CNT_W(CNT_W), .LEN_W(WORD_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cnt_clr),
    .add_en  (seg_fin),
    .add_val (desc_len),
    .cnt     (dev_byte_cnt)
  );

  always_comb begin
    state_d = state;
    case (state)
      ST_IDLE, ST_HALT: begin
        if (start_acc) state_d = ST_FETCH0;
      end
      ST_FETCH0, ST_FETCH1, ST_FETCH2: begin
        if (cmd_abort || fetch_bad)  state_d = ST_HALT;
        else if (fetch_ok) begin
          if (stop_eff)                state_d = ST_HALT;
          else if (state == ST_FETCH0) state_d = ST_FETCH1;
          else if (state == ST_FETCH1) state_d = ST_FETCH2;
          else if (len_zero)           state_d = ST_NEXT;
          else                         state_d = ST_XFER;
        end
      end
      ST_XFER: begin
        if (cmd_abort)    state_d = ST_HALT;
        else if (seg_fin) state_d = ST_NEXT;
      end
      ST_NEXT: begin
        if (cmd_abort || stop_eff) state_d = ST_HALT;
        else if (chain_end)        state_d = ST_IDLE;
        else                       state_d = ST_FETCH0;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      link_reg  <= '0;
      cur_desc  <= '0;
      stop_pend <= 1'b0;
      err_q     <= 1'b0;
      flush_q   <= 1'b0;
    end else begin
      state <= state_d;
      if (link_wr) link_reg <= link_wdata;
      if (start_acc)
        cur_desc <= link_reg;
      else if ((state == ST_NEXT) && (state_d == ST_FETCH0))
        cur_desc <= ADDR_W'(desc_next);
      stop_pend <= start_acc ? 1'b0 : (stop_pend || (cmd_stop && running));
      err_q     <= fetch_bad;
      flush_q   <= abort_acc;
    end
  end

  assign mem_rd_req    = fetching;
  assign mem_rd_addr   = cur_desc + ADDR_W'(slot_offset(fetch_slot(state)));
  assign seg_valid     = (state == ST_XFER);
  assign seg_addr      = ADDR_W'(desc_buf);
  assign seg_len       = desc_len;
  assign evt_link_done = (state == ST_NEXT);
  assign evt_xfer_err  = err_q;
  assign seg_flush     = flush_q;
  assign active        = running;

  AST_RESET_QUIET: assert property (@(posedge clk)
    $rose(rst_n) |-> (!mem_rd_req && !seg_valid && !evt_link_done)); // R1

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_ack && !cmd_abort) |=> (mem_rd_req && $stable(mem_rd_addr))); // R2

  AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && !seg_done && !cmd_abort) |=> (seg_valid && $stable(seg_addr) && $stable(seg_len))); // R3

  AST_SEG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (seg_len != '0)); // R4

  AST_LINK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_link_done |=> !evt_link_done); // R4

  AST_ABORT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cmd_abort) |=> (!active && seg_flush && !mem_rd_req && !seg_valid)); // R7

  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && mem_rd_ack && mem_rd_err && !cmd_abort) |=> (!active && evt_xfer_err)); // R9

  AST_ONE_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd_req, seg_valid, evt_link_done})); // R3
endmodule

// File: tb/ldr_seq_tb.sv
module ldr_seq_tb;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 0, cmd_stop = 0, cmd_abort = 0;
  logic        link_wr = 0;
  logic [31:0] link_wdata = '0;
  logic        cnt_clr = 0;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_ack = 0;
  logic [31:0] mem_rd_data = '0;
  logic        mem_rd_err = 0;
  logic        seg_valid;
  logic [31:0] seg_addr, seg_len;
  logic        seg_done = 0;
  logic        seg_flush, evt_link_done, evt_xfer_err, active;
  logic [31:0] dev_byte_cnt;

  always #2.5 clk = ~clk;

  ldr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_abort(cmd_abort), .link_wr(link_wr), .link_wdata(link_wdata),
    .cnt_clr(cnt_clr), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data), .mem_rd_err(mem_rd_err),
    .seg_valid(seg_valid), .seg_addr(seg_addr), .seg_len(seg_len),
    .seg_done(seg_done), .seg_flush(seg_flush), .evt_link_done(evt_link_done),
    .evt_xfer_err(evt_xfer_err), .dev_byte_cnt(dev_byte_cnt), .active(active)
  );

  int errors = 0, checks = 0;
  int link_seen = 0, seg_seen = 0, err_seen = 0, flush_seen = 0;
  bit mv_hold = 0, clr_on_done = 0;
  int mv_wait = 0;
  logic prev_seg = 0;
  logic [31:0] mem [int unsigned];

  // Behavioural reference: phase 0 idle, 1..3 reading word 1..3, 4 moving,
  // 5 link finished, 6 halted.
  int          ph = 0;
  logic [31:0] m_link = 0, m_cur = 0, m_cnt = 0, m_len = 0, m_buf = 0, m_nx = 0;
  bit          m_stop = 0, m_err = 0, m_flush = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; m_link = 0; m_cur = 0; m_cnt = 0; m_len = 0; m_buf = 0; m_nx = 0;
      m_stop = 0; m_err = 0; m_flush = 0;
    end else begin
      bit was_act, stop_now, done_now;
      was_act  = (ph >= 1 && ph <= 5);
      stop_now = m_stop || cmd_stop;
      done_now = 0;
      m_err = 0; m_flush = 0;
      if (ph == 0 || ph == 6) begin
        if (cmd_start && !cmd_abort) begin ph = 1; m_cur = m_link; m_stop = 0; end
      end else if (cmd_abort) begin
        ph = 6; m_flush = 1;
      end else if (ph <= 3) begin
        if (mem_rd_ack) begin
          if (mem_rd_err) begin ph = 6; m_err = 1; end
          else begin
            if (ph == 1) m_len = mem_rd_data;
            else if (ph == 2) m_buf = mem_rd_data;
            else m_nx = mem_rd_data;
            if (stop_now) ph = 6;
            else if (ph < 3) ph = ph + 1;
            else ph = (m_len == 0) ? 5 : 4;
          end
        end
      end else if (ph == 4) begin
        if (seg_done) begin done_now = 1; ph = 5; end
      end else begin
        if (stop_now) ph = 6;
        else if (m_nx == 0) ph = 0;
        else begin m_cur = m_nx; ph = 1; end
      end
      if (was_act && cmd_stop) m_stop = 1;
      m_cnt = (cnt_clr ? 32'd0 : m_cnt) + (done_now ? m_len : 32'd0);
      if (link_wr) m_link = link_wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'hBAD0_0000;
  endfunction

  task automatic put_desc(input logic [31:0] a, input logic [31:0] len,
                          input logic [31:0] b, input logic [31:0] nx);
    mem[a] = len; mem[a + 4] = b; mem[a + 8] = nx;
  endtask

  // One cycle: compare at the falling edge, then drive responders.
  task automatic tick();
    bit exp_req;
    @(negedge clk);
    exp_req = (ph >= 1 && ph <= 3);
    chk(mem_rd_req == exp_req, "R2 mem_rd_req", 32'(mem_rd_req), 32'(exp_req));
    if (exp_req)
      chk(mem_rd_addr == m_cur + 32'((ph - 1) * 4), "R2 mem_rd_addr", mem_rd_addr, m_cur + 32'((ph - 1) * 4));
    chk(seg_valid == (ph == 4), "R3 seg_valid", 32'(seg_valid), 32'(ph == 4));
    if (ph == 4) begin
      chk(seg_len == m_len, "R3 seg_len", seg_len, m_len);
      chk(seg_addr == m_buf, "R3 seg_addr", seg_addr, m_buf);
    end
    chk(evt_link_done == (ph == 5), "R4 evt_link_done", 32'(evt_link_done), 32'(ph == 5));
    chk(dev_byte_cnt == m_cnt, "R6 dev_byte_cnt", dev_byte_cnt, m_cnt);
    chk(seg_flush == m_flush, "R7 seg_flush", 32'(seg_flush), 32'(m_flush));
    chk(evt_xfer_err == m_err, "R9 evt_xfer_err", 32'(evt_xfer_err), 32'(m_err));
    chk(active == (ph >= 1 && ph <= 5), "R10 active", 32'(active), 32'(ph >= 1 && ph <= 5));
    if (evt_link_done) link_seen++;
    if (evt_xfer_err) err_seen++;
    if (seg_flush) flush_seen++;
    if (seg_valid && !prev_seg) seg_seen++;
    prev_seg = seg_valid;
    cmd_start = 0; cmd_stop = 0; cmd_abort = 0; link_wr = 0; cnt_clr = 0;
    if (mem_rd_req && ($urandom % 3 != 0)) begin
      mem_rd_ack = 1; mem_rd_data = rd(mem_rd_addr); mem_rd_err = (mem_rd_addr == 32'h304);
    end else begin
      mem_rd_ack = 0; mem_rd_data = 32'h0; mem_rd_err = 0;
    end
    seg_done = 0;
    if (seg_valid && !mv_hold) begin
      if (mv_wait == 0) begin
        seg_done = 1; mv_wait = $urandom % 3;
        if (clr_on_done) cnt_clr = 1;
      end else mv_wait--;
    end
  endtask

  task automatic run_idle();
    tick();
    for (int i = 0; i < 2000 && active; i++) tick();
  endtask

  task automatic set_link(input logic [31:0] a);
    link_wr = 1; link_wdata = a; tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int l0, s0, e0, f0;
    logic [31:0] c0, len0;
    put_desc(32'h200, 32'd16, 32'h3000, 32'h210);
    put_desc(32'h210, 32'd8,  32'h3100, 32'h0);
    put_desc(32'h100, 32'd64, 32'h1000, 32'h110);
    put_desc(32'h110, 32'd0,  32'h1800, 32'h120);
    put_desc(32'h120, 32'd20, 32'h2000, 32'h100);
    put_desc(32'h300, 32'd12, 32'h4000, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    // R1 reset state
    chk(!active && !mem_rd_req && !seg_valid && dev_byte_cnt == 0, "R1 reset", {active, mem_rd_req, seg_valid}, 0);

    // Terminated chain: R5 end, R6 sum
    set_link(32'h200);
    cmd_start = 1; run_idle();
    chk(dev_byte_cnt == 32'd24, "R6 chain sum", dev_byte_cnt, 32'd24);
    chk(link_seen == 2, "R5 chain links", link_seen, 2);
    chk(!active, "R5 chain end inactive", 32'(active), 0);

    // Ring with a zero-count link: R4, R5
    cnt_clr = 1; tick();
    chk(dev_byte_cnt == 0, "R6 clear", dev_byte_cnt, 0);
    set_link(32'h100);
    l0 = link_seen; s0 = seg_seen;
    cmd_start = 1; tick();
    for (int i = 0; i < 3000 && link_seen < l0 + 7; i++) tick();
    chk(dev_byte_cnt == 32'd232, "R5 ring laps sum", dev_byte_cnt, 32'd232);
    chk(seg_seen - s0 == 5, "R4 zero count skipped", seg_seen - s0, 5);

    // Start while running is ignored: R10
    mv_hold = 1;
    for (int i = 0; i < 200 && !seg_valid; i++) tick();
    len0 = seg_len;
    cmd_start = 1; tick();
    chk(seg_valid && !mem_rd_req && seg_len == len0, "R10 start ignored", {seg_valid, mem_rd_req}, 32'h2);

    // Stop during a segment: R8
    c0 = dev_byte_cnt; l0 = link_seen; s0 = seg_seen;
    cmd_stop = 1; mv_hold = 0;
    run_idle();
    chk(dev_byte_cnt == c0 + len0, "R8 stop completes segment", dev_byte_cnt, c0 + len0);
    chk(link_seen == l0 + 1, "R8 stop link event", link_seen, l0 + 1);
    chk(seg_seen == s0, "R8 no new segment", seg_seen, s0);

    // Stop ignored while inactive, restart from halt: R10
    cmd_stop = 1; tick();
    set_link(32'h200);
    c0 = dev_byte_cnt;
    cmd_start = 1; run_idle();
    chk(dev_byte_cnt == c0 + 24, "R10 restart from halt", dev_byte_cnt, c0 + 24);

    // Abort mid-segment: R7
    set_link(32'h100);
    mv_hold = 1; f0 = flush_seen;
    cmd_start = 1; tick();
    for (int i = 0; i < 200 && !seg_valid; i++) tick();
    c0 = dev_byte_cnt;
    cmd_abort = 1; tick();
    chk(!active && seg_flush, "R7 abort in segment", {active, seg_flush}, 32'h1);
    chk(dev_byte_cnt == c0, "R7 abort no count", dev_byte_cnt, c0);
    mv_hold = 0;

    // Abort during fetch: R7
    cmd_start = 1; tick();
    chk(mem_rd_req, "R7 fetching before abort", 32'(mem_rd_req), 1);
    cmd_abort = 1; tick();
    chk(!active && !mem_rd_req && flush_seen == f0 + 2, "R7 abort in fetch", flush_seen, f0 + 2);

    // Link write in the same cycle as start: R2
    link_wr = 1; link_wdata = 32'h200; cmd_start = 1; tick();
    chk(mem_rd_addr == 32'h100, "R2 start uses old link", mem_rd_addr, 32'h100);
    cmd_abort = 1; tick();
    cmd_start = 1; tick();
    chk(mem_rd_addr == 32'h200, "R2 new link next start", mem_rd_addr, 32'h200);
    cmd_abort = 1; tick();

    // Stop during fetch: R8
    s0 = seg_seen; l0 = link_seen;
    cmd_start = 1; tick();
    cmd_stop = 1; run_idle();
    chk(seg_seen == s0 && link_seen == l0, "R8 stop in fetch", seg_seen - s0, 0);

    // Read error: R9
    set_link(32'h300);
    e0 = err_seen; s0 = seg_seen;
    cmd_start = 1; run_idle();
    chk(err_seen == e0 + 1, "R9 error event", err_seen, e0 + 1);
    chk(seg_seen == s0, "R9 no segment", seg_seen, s0);

    // Clear coinciding with completion: R6
    set_link(32'h200);
    clr_on_done = 1;
    cmd_start = 1; run_idle();
    chk(dev_byte_cnt == 32'd8, "R6 clear with completion", dev_byte_cnt, 32'd8);
    clr_on_done = 0;
    tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule